// File: doc/BRIEF.md
# Receive Message Queue with Key-Release Pointer

This block holds complete received messages for a CAN-style controller until software has read them. A message arrives on a one-cycle receive strobe and carries an identifier, a timestamp, a pointer field and four data words. Software sees the oldest unread message through a set of read-window registers. When it has finished with that message, it releases it by writing the key byte FFh to a pointer-control register. Any other value written there is ignored.

A control register holds the enable bit and the interrupt configuration. A status register reports the unread count, the empty and full flags, a sticky lost-message flag and a sticky interrupt request flag. A two-bit global mode input decides whether software may clear the interrupt flag. One of its values forces the flag low. Register reads return data one clock after the address is presented.

Register map (4-bit word address): 0 control, 1 status, 2 pointer control, 3 head identifier, 4 head timestamp, 5 head pointer field, 6 to 9 head data words 0 to 3. Any other address reads zero.

Top module: `rx_msg_fifo`

## Requirements
- R1: A cycle with `rx_valid` high, while the block is enabled and the queue is not full, appends the message to the queue and raises the unread count by one.
- R2: A message is released only by a write to address 2 whose low byte is FFh, made while the block is enabled and the queue is not empty. A release lowers the count by one. Any other value, and any such write while disabled or empty, changes neither the count nor the head message.
- R3: Status is at address 1: bit 0 is empty, bit 1 is full, bit 2 is lost, bit 3 is the interrupt flag, and bits 13:8 hold the 6-bit unread count. The count never exceeds DEPTH, and full reads 1 exactly when the count equals DEPTH. A store and a release in the same cycle leave the count unchanged.
- R4: Addresses 3 to 9 show the oldest unread message: identifier, timestamp, pointer field, then data words 0 to 3, each zero-extended to 32 bits. After a release, they show the next message.
- R5: Control is at address 0: bit 0 is enable. While enable is 0, status reads count 0, empty 1 and full 0, and `rx_valid` is ignored. Clearing enable empties the queue and clears the lost flag, so the queue reads empty when it is enabled again.
- R6: A store attempted while the queue is full is dropped and sets the lost flag (status bit 2). The flag stays set until the block is disabled.
- R7: With control bit 1 set, every stored message sets the interrupt flag.
- R8: With control bit 1 clear, the interrupt flag is set by a store after which the count equals DEPTH*(code+1)/8. Here code is control bits 4:2.
- R9: Writing status with bit 3 equal to 0 clears the interrupt flag only when `gmode` is 00 (operating) or 10 (test). In mode 11 the write is ignored. Writing bit 3 as 1 never changes the flag.
- R10: While `gmode` is 01 (global reset), the interrupt flag is forced to 0.
- R11: Address 2 always reads zero. Its bits 15:8 have no effect: the decision to release depends on bits 7:0 alone.
- R12: `reg_rdata` is registered. It shows the register selected by `reg_addr` one clock earlier. Control reads back enable, bit 1 and the code in bits 4:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gmode | input | 2 | Global mode: 00 operating, 01 reset, 10 test, 11 halt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Incoming message strobe |
| rx_id | input | ID_W | Incoming identifier |
| rx_ts | input | TS_W | Incoming timestamp |
| rx_pf | input | PF_W | Incoming pointer field |
| rx_data | input | NW*DW | Incoming data words, word 0 in the low bits |
| irq_o | output | 1 | Interrupt request flag |

## Verification
A behavioural queue model predicts the read data and the interrupt flag on every clock. Stores are tried alone, back to back up to full and beyond, and in the same cycle as a release. This separates the count arithmetic from the overflow handling. Release writes are sent with wrong key bytes, with non-zero reserved bits, and to an empty or disabled queue, so that the key decode is told apart from the guard conditions. Clears of the interrupt flag are applied in each global mode, and the threshold and every-message settings are exercised.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    GM_OPER  = 2'b00,
    GM_RESET = 2'b01,
    GM_TEST  = 2'b10,
    GM_HALT  = 2'b11
  } gmode_e;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_STAT = 4'd1;
  localparam logic [3:0] A_PCTL = 4'd2;
  localparam logic [3:0] A_HID  = 4'd3;
  localparam logic [3:0] A_HTS  = 4'd4;
  localparam logic [3:0] A_HPF  = 4'd5;
  localparam logic [3:0] A_HD0  = 4'd6;

  localparam logic [7:0] POP_KEY = 8'hFF;

  // fill level at which the threshold interrupt fires
  function automatic int unsigned thr_level(int unsigned depth, logic [2:0] code);
    return (depth * (32'(code) + 32'd1)) / 32'd8;
  endfunction
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int DEPTH = 16,
  parameter int MW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [MW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [MW-1:0] head
);
  logic [MW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // synchronous read of the next head slot, forwarding a same-cycle write
  always_ff @(posedge clk) begin
    if (we && waddr == raddr) head <= wdata;
    else                      head <= mem[raddr];
  end

  assert_head_fwd_R4: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == raddr) |=> head == $past(wdata));
endmodule

// File: rtl/rxf_ptr.sv
module rxf_ptr #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr_nxt,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          empty,
  output logic          full,
  output logic          lost
);
  logic [AW-1:0] rd_ptr;
  logic          pop;
  logic          drop;

  assign push = en && push_req && !full;
  assign pop  = en && pop_req && !empty;
  assign drop = en && push_req && full;

  assign cnt_nxt    = cnt + CW'(push) - CW'(pop);
  assign rd_ptr_nxt = en ? rd_ptr + AW'(pop) : '0;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
      lost   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
      empty  <= (cnt_nxt == '0);
      full   <= (cnt_nxt == CW'(DEPTH));
      if (drop) lost <= 1'b1;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_full_flag_R3: assert property (@(posedge clk) disable iff (rst)
    full == (cnt == CW'(DEPTH)));
  assert_pop_dec_R2: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> cnt == $past(cnt) - CW'(1));
  assert_both_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(cnt));
  assert_push_inc_R1: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> cnt == $past(cnt) + CW'(1));
  assert_disabled_empty_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && empty && !lost));
  assert_lost_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (lost && en) |=> lost);
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  gmode_e        gm,
  input  logic          push,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          every,
  input  logic [2:0]    code,
  input  logic          clr_wr,
  output logic          irq
);
  logic set_req;
  logic clr_ok;

  assign set_req = push && (every || 32'(cnt_nxt) == thr_level(DEPTH, code));
  assign clr_ok  = clr_wr && (gm == GM_OPER || gm == GM_TEST);

  always_ff @(posedge clk) begin
    if (rst || gm == GM_RESET) irq <= 1'b0;
    else if (set_req)          irq <= 1'b1;
    else if (clr_ok)           irq <= 1'b0;
  end

  assert_greset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (gm == GM_RESET) |=> !irq);
  assert_every_set_R7: assert property (@(posedge clk) disable iff (rst)
    (push && every && gm != GM_RESET) |=> irq);
  assert_halt_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && gm == GM_HALT) |=> irq);
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 29,
  parameter int TS_W  = 16,
  parameter int PF_W  = 16,
  parameter int DW    = 32,
  parameter int NW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int MW   = ID_W + TS_W + PF_W + NW * DW,
  localparam int O_PF = NW * DW,
  localparam int O_TS = O_PF + PF_W,
  localparam int O_ID = O_TS + TS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         gmode,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               rx_valid,
  input  logic [ID_W-1:0]    rx_id,
  input  logic [TS_W-1:0]    rx_ts,
  input  logic [PF_W-1:0]    rx_pf,
  input  logic [NW*DW-1:0]   rx_data,
  output logic               irq_o
);
  gmode_e        gm;
  logic          en, every;
  logic [2:0]    code;
  logic          pop_req, clr_wr, push;
  logic [AW-1:0] wr_ptr, rd_ptr_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          empty, full, lost;
  logic [MW-1:0] wmsg, head;
  logic [5:0]    cnt_vis;
  logic [31:0]   rd_mux;
  logic          unused_wbits;

  assign gm           = gmode_e'(gmode);
  assign unused_wbits = ^reg_wdata[15:8];

  assign pop_req = reg_wr && reg_addr == A_PCTL && reg_wdata[7:0] == POP_KEY;
  assign clr_wr  = reg_wr && reg_addr == A_STAT && !reg_wdata[3];
  assign wmsg    = {rx_id, rx_ts, rx_pf, rx_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      every <= 1'b0;
      code  <= 3'd0;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      en    <= reg_wdata[0];
      every <= reg_wdata[1];
      code  <= reg_wdata[4:2];
    end
  end

  rxf_ptr #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst(rst), .en(en), .push_req(rx_valid), .pop_req(pop_req),
    .push(push), .wr_ptr(wr_ptr), .rd_ptr_nxt(rd_ptr_nxt), .cnt(cnt),
    .cnt_nxt(cnt_nxt), .empty(empty), .full(full), .lost(lost)
  );

  rxf_mem #(.DEPTH(DEPTH), .MW(MW)) mem_i (
    .clk(clk), .rst(rst), .we(push), .waddr(wr_ptr), .wdata(wmsg),
    .raddr(rd_ptr_nxt), .head(head)
  );

  rxf_irq #(.DEPTH(DEPTH)) irq_i (
    .clk(clk), .rst(rst), .gm(gm), .push(push), .cnt_nxt(cnt_nxt),
    .every(every), .code(code), .clr_wr(clr_wr), .irq(irq_o)
  );

  assign cnt_vis = en ? 6'(cnt) : 6'd0;

  always_comb begin
    rd_mux = 32'd0;
    case (reg_addr)
      A_CTRL: rd_mux = {27'd0, code, every, en};
      A_STAT: rd_mux = {18'd0, cnt_vis, 4'd0, irq_o, lost, en && full, !en || empty};
      A_HID:  rd_mux = 32'(head[O_ID +: ID_W]);
      A_HTS:  rd_mux = 32'(head[O_TS +: TS_W]);
      A_HPF:  rd_mux = 32'(head[O_PF +: PF_W]);
      default: rd_mux = 32'd0;
    endcase
    for (int k = 0; k < NW; k++) begin
      if (reg_addr == A_HD0 + 4'(k)) rd_mux = 32'(head[k*DW +: DW]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 32'd0;
    else     reg_rdata <= rd_mux;
  end

  assert_pctl_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_PCTL) |=> reg_rdata == 32'd0);
  assert_disabled_stat_R5: assert property (@(posedge clk) disable iff (rst)
    (!en && reg_addr == A_STAT) |=> (reg_rdata[13:8] == 6'd0 && reg_rdata[0] && !reg_rdata[1]));
endmodule

// File: tb/rx_msg_fifo_tb.sv
module rx_msg_fifo_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   gmode = 2'b00;
  logic         reg_wr = 1'b0;
  logic [3:0]   reg_addr = 4'd0;
  logic [15:0]  reg_wdata = 16'd0;
  logic [31:0]  reg_rdata;
  logic         rx_valid = 1'b0;
  logic [28:0]  rx_id = '0;
  logic [15:0]  rx_ts = '0;
  logic [15:0]  rx_pf = '0;
  logic [127:0] rx_data = '0;
  logic         irq_o;

  int checks = 0;
  int fails  = 0;
  int seq    = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_msg_fifo dut_i (
    .clk(clk), .rst(rst), .gmode(gmode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_id(rx_id), .rx_ts(rx_ts), .rx_pf(rx_pf), .rx_data(rx_data), .irq_o(irq_o)
  );

  // ---------------- behavioural model ----------------
  typedef struct {
    logic [28:0]  id;
    logic [15:0]  ts;
    logic [15:0]  pf;
    logic [127:0] data;
  } msg_t;

  msg_t        q[$];
  logic        m_en = 0, m_every = 0, m_lost = 0, m_irq = 0;
  logic [2:0]  m_code = 0;
  logic [31:0] exp_rd = 0;
  logic        chk_on = 0;
  string       chk_tag = "R12";

  function automatic logic [31:0] model_read(logic [3:0] a);
    logic [31:0] r;
    r = 32'd0;
    if (a == 4'd0) r = {27'd0, m_code, m_every, m_en};
    else if (a == 4'd1) begin
      if (m_en) r = {18'd0, 6'(q.size()), 4'd0, m_irq, m_lost,
                     q.size() == DEPTH, q.size() == 0};
      else      r = {28'd0, m_irq, m_lost, 2'b01};
    end else if (a >= 4'd3 && a <= 4'd9 && q.size() > 0) begin
      case (a)
        4'd3: r = 32'(q[0].id);
        4'd4: r = 32'(q[0].ts);
        4'd5: r = 32'(q[0].pf);
        default: r = q[0].data[(int'(a) - 6) * 32 +: 32];
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_en = 0; m_every = 0; m_code = 0; m_lost = 0; m_irq = 0;
      chk_on = 0;
    end else begin
      logic push, pop, full_drop, clr;
      msg_t m;
      exp_rd = model_read(reg_addr);
      chk_on = 1;
      case (reg_addr)
        4'd0: chk_tag = "R12";
        4'd1: chk_tag = "R3";
        4'd2: chk_tag = "R11";
        default: chk_tag = "R4";
      endcase
      if (reg_addr >= 4'd3 && reg_addr <= 4'd9 && (!m_en || q.size() == 0)) chk_on = 0;
      push      = rx_valid && m_en && q.size() < DEPTH;
      full_drop = rx_valid && m_en && q.size() == DEPTH;
      pop       = reg_wr && reg_addr == 4'd2 && reg_wdata[7:0] == 8'hFF && m_en && q.size() > 0;
      clr       = reg_wr && reg_addr == 4'd1 && !reg_wdata[3] && (gmode == 2'b00 || gmode == 2'b10);
      if (!m_en) begin
        q.delete();
        m_lost = 0;
      end else begin
        if (pop) void'(q.pop_front());
        if (push) begin
          m.id = rx_id; m.ts = rx_ts; m.pf = rx_pf; m.data = rx_data;
          q.push_back(m);
        end
        if (full_drop) m_lost = 1;
      end
      if (gmode == 2'b01) m_irq = 0;
      else if (push && (m_every || q.size() == DEPTH * (int'(m_code) + 1) / 8)) m_irq = 1;
      else if (clr) m_irq = 0;
      if (reg_wr && reg_addr == 4'd0) begin
        m_en = reg_wdata[0]; m_every = reg_wdata[1]; m_code = reg_wdata[4:2];
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && chk_on) begin
      checks++;
      if (reg_rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s model read addr=%0d actual=%h expected=%h", chk_tag, reg_addr, reg_rdata, exp_rd);
      end
      checks++;
      if (irq_o !== m_irq) begin
        fails++;
        $display("FAIL R7 irq_o vs model actual=%b expected=%b", irq_o, m_irq);
      end
    end
  end

  // ---------------- stimulus tasks (entered just after a falling edge) ----------------
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 16'd0;
  endtask

  task automatic set_msg();
    rx_id = 29'h0100_0000 + 29'(seq);
    rx_ts = 16'(seq * 7);
    rx_pf = 16'(seq) ^ 16'h00A5;
    for (int k = 0; k < 4; k++) rx_data[k*32 +: 32] = 32'hD000_0000 | (32'(seq) << 4) | 32'(k);
    seq++;
  endtask

  task automatic push_msg();
    set_msg();
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s directed read addr=%0d actual=%h expected=%h", tag, a, reg_rdata, e);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd_chk(4'd0, 32'h0, "R12");              // reset state
    rd_chk(4'd1, 32'h1, "R5");               // disabled: empty
    wr(4'd0, 16'h0005);                      // enable, threshold code 1 -> level 4
    rd_chk(4'd0, 32'h5, "R12");
    repeat (3) push_msg();
    rd_chk(4'd1, 32'h0300, "R1");            // count 3, no irq yet (R8)
    push_msg();
    rd_chk(4'd1, 32'h0408, "R8");            // level 4 reached
    rd_chk(4'd3, 32'h0100_0000, "R4");       // head is message 0
    wr(4'd2, 16'h00FE);
    rd_chk(4'd1, 32'h0408, "R2");            // wrong key ignored
    wr(4'd2, 16'hFF00);
    rd_chk(4'd1, 32'h0408, "R11");           // key in reserved byte ignored
    wr(4'd2, 16'hABFF);
    rd_chk(4'd1, 32'h0308, "R11");           // reserved bits do not block release
    rd_chk(4'd3, 32'h0100_0001, "R4");       // head moved to message 1
    rd_chk(4'd7, 32'hD000_0011, "R4");       // data word 1 of message 1
    rd_chk(4'd2, 32'h0, "R11");
    gmode = 2'b11;
    wr(4'd1, 16'h0000);
    rd_chk(4'd1, 32'h0308, "R9");            // clear ignored in halt
    gmode = 2'b00;
    wr(4'd1, 16'h0008);
    rd_chk(4'd1, 32'h0308, "R9");            // writing 1 keeps it
    wr(4'd1, 16'h0000);
    rd_chk(4'd1, 32'h0300, "R9");            // cleared in operating mode
    set_msg();
    rx_valid = 1'b1; reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 16'h00FF;
    @(negedge clk);
    rx_valid = 1'b0; reg_wr = 1'b0; reg_wdata = 16'd0;
    rd_chk(4'd1, 32'h0300, "R3");            // store + release together
    repeat (13) push_msg();
    rd_chk(4'd1, 32'h100A, "R3");            // full at 16, irq from level 4
    push_msg();
    rd_chk(4'd1, 32'h100E, "R6");            // overflow sets lost
    gmode = 2'b01;
    rd_chk(4'd1, 32'h1006, "R10");           // global reset clears irq
    gmode = 2'b00;
    wr(4'd0, 16'h0003);                      // every-message mode
    for (int i = 0; i < 16; i++) wr(4'd2, 16'h00FF);
    rd_chk(4'd1, 32'h0005, "R6");            // drained, lost still set
    push_msg();
    rd_chk(4'd1, 32'h010C, "R7");
    wr(4'd0, 16'h0000);
    rd_chk(4'd1, 32'h0009, "R5");            // disabled view, lost cleared
    push_msg();
    wr(4'd0, 16'h0001);
    rd_chk(4'd1, 32'h0009, "R5");            // store while disabled ignored
    wr(4'd2, 16'h00FF);
    rd_chk(4'd1, 32'h0009, "R2");            // release on empty ignored
    push_msg();
    rd_chk(4'd1, 32'h0100 | 32'h8, "R1");
    rd_chk(4'd4, 32'(16'((seq - 1) * 7)), "R4");
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule